// File: doc/BRIEF.md
# Chunked Hamming Parity Generator for NAND Pages

This block computes a single-error-correcting Hamming parity word over flash page data as the bytes stream through it. It works on fixed chunks of 256 bytes, so the parity restarts at every chunk boundary. When the last byte of a chunk is accepted, the result is latched into a readable ECC register and a one-cycle done pulse is raised. The accumulator then restarts for the next chunk without losing a cycle. A 512-byte page gives two chunks and six code bytes. A 2048-byte page gives eight chunks.

The latched parity word is also turned into a 3-byte spare-area code. The word is shifted left by two, inverted, and cut to 24 bits. The three bytes come out most significant first. A controller uses the block with data moving in either direction: bytes are counted only while the enable input is high, and a clear pulse starts a fresh chunk. Correcting data on readback and placing the code bytes in the spare area are done elsewhere.

Top module: `hamming_chunk_ecc`

## Requirements
- R1: After reset the ECC register reads 0 and the done output is low. Each of the three spare bytes reads 8'hFF.
- R2: Line parity sits in parity bits 15:0. For each byte-address bit k (0..7) within the chunk, bit 2k is the XOR of every data bit in bytes whose address bit k is 0, and bit 2k+1 covers the bytes whose address bit k is 1.
- R3: Column parity sits in parity bits 21:16. For each bit-position level j (0..2), bit 16+2j is the XOR of data bits whose bit index has bit j equal to 0, and bit 17+2j covers the index bits equal to 1. Bits 23:22 are always 0.
- R4: On the clock edge that accepts the 256th byte of a chunk, the ECC register takes the parity of the whole chunk, including that byte. The done output is high for exactly the following cycle. A byte presented on that following cycle counts as byte 0 of the next chunk.
- R5: The ECC register holds its value in every cycle except the one after a chunk completes.
- R6: A byte presented while the enable input is low changes neither the parity nor the chunk byte count.
- R7: Cycles with the byte-valid input low change neither the parity nor the count.
- R8: A clear pulse empties the accumulator and resets the byte count, while the ECC register keeps its value. A byte presented in the same cycle as the clear is dropped, even if it would have been the 256th byte, and no done pulse follows.
- R9: Let the encoded code be the bitwise inverse of the ECC register shifted left by 2, keeping bits 23:0. The first spare output carries encoded bits 23:16, the second carries bits 15:8, and the third carries bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Clear pulse: restart the chunk |
| ecc_en_i | input | 1 | Accumulation enable |
| byte_valid_i | input | 1 | Data byte present this cycle |
| byte_i | input | 8 | Data byte |
| ecc_o | output | 24 | Latched raw parity word (ECC register) |
| chunk_done_o | output | 1 | One-cycle pulse after a chunk completes |
| spare0_o | output | 8 | Encoded code, bits 23:16 |
| spare1_o | output | 8 | Encoded code, bits 15:8 |
| spare2_o | output | 8 | Encoded code, bits 7:0 |

## Verification
Two actions can fall on the same cycle: the clear pulse and the acceptance of a chunk's 256th byte. If the block handles this wrong, the register could latch or a spurious done could fire. The bench provokes this case by sending 255 enabled bytes and then presenting the last byte together with clear. It then judges the result at the ports. In the next cycle done must be low and the ECC register must still hold the previous chunk's value. A following full chunk must produce parity over its own bytes only.

// File: rtl/ecc_chunk_pkg.sv
package ecc_chunk_pkg;
    localparam int DATA_W  = 8;
    localparam int COL_LVL = $clog2(DATA_W);
    localparam int ECC_W   = 24;
    localparam int SPARE_N = ECC_W / DATA_W;
    localparam int ENC_SHIFT = 2;

    typedef logic [ECC_W-1:0]  ecc_word_t;
    typedef logic [DATA_W-1:0] data_byte_t;

    typedef struct packed {
        ecc_word_t ecc;
        logic      done;
    } ecc_out_st_t;
endpackage

// File: rtl/ecc_chunk_counter.sv
module ecc_chunk_counter
    import ecc_chunk_pkg::*;
#(
    parameter int CHUNK_BYTES = 256,
    localparam int ADDR_W = $clog2(CHUNK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        last_o = (addr_q == ADDR_W'(CHUNK_BYTES - 1));
        addr_d = addr_q;
        if (clr)
            addr_d = '0;
        else if (step)
            addr_d = last_o ? '0 : addr_q + ADDR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/ecc_parity_accum.sv
module ecc_parity_accum
    import ecc_chunk_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int LINE_BITS = 2 * ADDR_W,
    localparam int COL_BASE  = LINE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              wrap,
    input  data_byte_t        data_i,
    input  logic [ADDR_W-1:0] addr_i,
    output ecc_word_t         with_byte_o
);
    ecc_word_t acc_d, acc_q;
    ecc_word_t contrib;
    logic      byte_par;

    always_comb begin
        contrib  = '0;
        byte_par = ^data_i;
        for (int k = 0; k < ADDR_W; k++) begin
            if (addr_i[k]) contrib[2*k+1] = byte_par;
            else           contrib[2*k]   = byte_par;
        end
        for (int j = 0; j < COL_LVL; j++) begin
            logic even_x, odd_x;
            even_x = 1'b0;
            odd_x  = 1'b0;
            for (int i = 0; i < DATA_W; i++) begin
                if (((i >> j) & 1) == 1) odd_x  = odd_x  ^ data_i[i];
                else                     even_x = even_x ^ data_i[i];
            end
            contrib[COL_BASE+2*j]   = even_x;
            contrib[COL_BASE+2*j+1] = odd_x;
        end
        with_byte_o = acc_q ^ contrib;

        acc_d = acc_q;
        if (clr)
            acc_d = '0;
        else if (step)
            acc_d = wrap ? '0 : with_byte_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/ecc_spare_format.sv
module ecc_spare_format
    import ecc_chunk_pkg::*;
(
    input  ecc_word_t                      raw_i,
    output logic [SPARE_N-1:0][DATA_W-1:0] bytes_o
);
    ecc_word_t enc;

    assign enc = ~(raw_i << ENC_SHIFT);

    for (genvar g = 0; g < SPARE_N; g++) begin : g_byte
        assign bytes_o[g] = enc[ECC_W-1-DATA_W*g -: DATA_W];
    end
endmodule

// File: rtl/hamming_chunk_ecc.sv
module hamming_chunk_ecc
    import ecc_chunk_pkg::*;
#(
    parameter int CHUNK_BYTES = 256,
    localparam int ADDR_W = $clog2(CHUNK_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       ecc_en_i,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_i,
    output logic [23:0] ecc_o,
    output logic       chunk_done_o,
    output logic [7:0] spare0_o,
    output logic [7:0] spare1_o,
    output logic [7:0] spare2_o
);
    logic              step, wrap, last;
    logic [ADDR_W-1:0] addr;
    ecc_word_t         with_byte;
    ecc_out_st_t       out_d, out_q;
    logic [SPARE_N-1:0][DATA_W-1:0] spare;

    assign step = byte_valid_i && ecc_en_i && !clr_i;
    assign wrap = step && last;

    ecc_chunk_counter #(.CHUNK_BYTES(CHUNK_BYTES)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_i), .step(step),
        .addr_o(addr), .last_o(last)
    );

    ecc_parity_accum #(.ADDR_W(ADDR_W)) i_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr_i), .step(step), .wrap(wrap),
        .data_i(byte_i), .addr_i(addr), .with_byte_o(with_byte)
    );

    always_comb begin
        out_d      = out_q;
        out_d.done = wrap;
        if (wrap) out_d.ecc = with_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    ecc_spare_format i_fmt (.raw_i(out_q.ecc), .bytes_o(spare));

    assign ecc_o        = out_q.ecc;
    assign chunk_done_o = out_q.done;
    assign spare0_o     = spare[0];
    assign spare1_o     = spare[1];
    assign spare2_o     = spare[2];
endmodule

// File: rtl/hamming_chunk_ecc_chk.sv
module hamming_chunk_ecc_chk #(
    parameter int ADDR_W = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        clr_i,
    input logic        ecc_en_i,
    input logic        byte_valid_i,
    input logic [23:0] ecc_o,
    input logic        chunk_done_o,
    input logic [7:0]  spare0_o,
    input logic [7:0]  spare1_o,
    input logic [7:0]  spare2_o
);
    localparam int PAIRS = ADDR_W + 3;
    logic [PAIRS-1:0] pair_x;

    always_comb begin
        for (int k = 0; k < PAIRS; k++) pair_x[k] = ecc_o[2*k] ^ ecc_o[2*k+1];
    end

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_done_o |=> !chunk_done_o);

    // R3
    top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_o[23:22] == 2'b00);

    // R5
    ecc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chunk_done_o |-> $stable(ecc_o));

    // R6
    gated_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_en_i || !byte_valid_i) |=> !chunk_done_o);

    // R8
    clr_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !chunk_done_o);

    // R2
    pair_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_done_o |-> (pair_x == '0 || pair_x == '1));

    // R9
    spare_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {spare0_o, spare1_o, spare2_o} == ~{ecc_o[21:0], 2'b00});
endmodule

bind hamming_chunk_ecc hamming_chunk_ecc_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .ecc_en_i(ecc_en_i),
    .byte_valid_i(byte_valid_i), .ecc_o(ecc_o), .chunk_done_o(chunk_done_o),
    .spare0_o(spare0_o), .spare1_o(spare1_o), .spare2_o(spare2_o)
);

// File: tb/test_hamming_chunk_ecc.sv
module test_hamming_chunk_ecc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, en = 1'b0, vld = 1'b0;
    logic [7:0] din = '0;
    logic [23:0] ecc;
    logic done;
    logic [7:0] s0, s1, s2;

    int checks = 0, fails = 0;
    logic [23:0] exp_q[$];
    logic [7:0]  chunk_buf[$];
    logic [15:0] lfsr = 16'hACE1;
    logic        finished = 1'b0;

    always #4 clk = ~clk;

    hamming_chunk_ecc i_hamming_chunk_ecc (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .ecc_en_i(en),
        .byte_valid_i(vld), .byte_i(din), .ecc_o(ecc), .chunk_done_o(done),
        .spare0_o(s0), .spare1_o(s1), .spare2_o(s2)
    );

    task automatic check(input bit ok, input string req, input logic [23:0] act,
                         input logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model: each set bit toggles one line bit per address bit and one column bit per level
    function automatic logic [23:0] model(input logic [7:0] b[$]);
        logic [23:0] p = '0;
        for (int a = 0; a < b.size(); a++)
            for (int i = 0; i < 8; i++)
                if (b[a][i]) begin
                    for (int k = 0; k < 8; k++) p[2*k + ((a >> k) & 1)] ^= 1'b1;
                    for (int j = 0; j < 3; j++) p[16 + 2*j + ((i >> j) & 1)] ^= 1'b1;
                end
        return p;
    endfunction

    task automatic drive(input logic [7:0] b, input bit e, input bit c);
        @(negedge clk);
        vld = 1'b1; din = b; en = e; clr = c;
        if (c) chunk_buf.delete();
        else if (e) begin
            chunk_buf.push_back(b);
            if (chunk_buf.size() == 256) begin
                exp_q.push_back(model(chunk_buf));
                chunk_buf.delete();
            end
        end
    endtask

    task automatic idle(input logic [7:0] junk);
        @(negedge clk);
        vld = 1'b0; din = junk; clr = 1'b0; en = 1'b1;
    endtask

    function automatic logic [7:0] next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[7:0];
    endfunction

    // Monitor: pops expected parity words as chunk results appear (R4, R2, R3, R9)
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected done", ecc, 24'h0);
            end else begin
                logic [23:0] e, enc;
                e = exp_q.pop_front();
                enc = ~(e << 2);
                check(ecc === e, "R2/R3 chunk parity", ecc, e);
                check({s0, s1, s2} === enc, "R9 spare bytes", {s0, s1, s2}, enc);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ecc === 24'h0, "R1 ecc reset", ecc, 24'h0);
        check(done === 1'b0, "R1 done reset", {23'h0, done}, 24'h0);
        check({s0, s1, s2} === 24'hFFFFFF, "R1 spare reset", {s0, s1, s2}, 24'hFFFFFF);
        rst_n = 1'b1;
        idle(8'h00);

        // Known single-bit chunk: byte 0x5A bit 3 set (R2, R3, R9)
        for (int a = 0; a < 256; a++) drive((a == 8'h5A) ? 8'h08 : 8'h00, 1'b1, 1'b0);
        idle(8'h00);
        check(ecc === 24'h1A6699, "R2/R3 known parity", ecc, 24'h1A6699);
        check({s0, s1, s2} === 24'h96659B, "R9 known spare", {s0, s1, s2}, 24'h96659B);
        check(done === 1'b1, "R4 done after last byte", {23'h0, done}, 24'h1);
        idle(8'h00);
        check(done === 1'b0, "R4 done one cycle", {23'h0, done}, 24'h0);

        // Back-to-back chunks: incrementing then random, no gap (R4)
        for (int a = 0; a < 256; a++) drive(8'(a), 1'b1, 1'b0);
        for (int a = 0; a < 256; a++) drive(next_rand(), 1'b1, 1'b0);
        idle(8'h00);
        idle(8'h00);

        // Chunk with valid gaps and enable-low junk bytes (R6, R7)
        for (int a = 0; a < 256; a++) begin
            drive(next_rand(), 1'b1, 1'b0);
            if (a % 7 == 3) idle(8'hFF);
            if (a % 5 == 1) drive(8'hA5, 1'b0, 1'b0);
        end
        idle(8'h00);
        held = ecc;
        repeat (20) drive(8'h3C, 1'b0, 1'b0);
        idle(8'h00);
        check(ecc === held, "R5/R6 hold while disabled", ecc, held);

        // Clear mid-chunk (R8)
        for (int a = 0; a < 100; a++) drive(next_rand(), 1'b1, 1'b0);
        drive(8'h77, 1'b1, 1'b1);
        idle(8'h00);
        check(ecc === held, "R8 clear keeps register", ecc, held);
        for (int a = 0; a < 256; a++) drive(next_rand(), 1'b1, 1'b0);
        idle(8'h00);
        idle(8'h00);
        held = ecc;

        // Clear together with the 256th byte (R8)
        for (int a = 0; a < 255; a++) drive(next_rand(), 1'b1, 1'b0);
        drive(8'h81, 1'b1, 1'b1);
        idle(8'h00);
        check(done === 1'b0, "R8 no done on clear+last", {23'h0, done}, 24'h0);
        check(ecc === held, "R8 register unchanged", ecc, held);
        for (int a = 0; a < 256; a++) drive(8'hFF - 8'(a), 1'b1, 1'b0);
        idle(8'h00);
        idle(8'h00);

        check(exp_q.size() == 0, "R4 all chunks reported", 24'(exp_q.size()), 24'h0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule